// File: doc/BRIEF.md
# Critical-Word-First Line Fill Unit

This unit handles a single outstanding cache miss for a line of several words. When the CPU misses, the unit sends one request to memory. The request names the line and the word the CPU is waiting for. Memory then returns the line one word per beat. The wanted word comes first, and the remaining words follow in wrap-around order. The unit writes each beat into the data array at the word's true position. On the first beat it also hands the word straight to the CPU in the same cycle, so the CPU can restart while the rest of the line streams in behind it.

While the fill is in progress the CPU may read one more word of the same line. If that word has already arrived, it is returned at once from a small line buffer. If it has not, the unit raises a stall flag and returns the word in the cycle it comes back from memory. A busy flag covers the whole fill and blocks new misses. A line-valid flag is set only after the last word has been written.

Top module: `cwf_line_fill`

## Requirements
- R1: A miss (`miss_valid`) is accepted only in a cycle where `fill_busy` is low. In that same cycle `mem_req_valid` is high, and `mem_req_line` and `mem_req_off` equal `miss_line` and `miss_off`, so the missed word is the one asked for first.
- R2: `fill_busy` goes high in the cycle after a miss is accepted. It stays high through the cycle that writes the last word of the line and is low in the cycle after that. A miss presented while `fill_busy` is high produces no request.
- R3: The k-th beat returned from memory (k counted from 0) is written in its own cycle. `arr_we` is high, `arr_off` = (`miss_off` + k) mod WORDS, `arr_line` is the accepted line and `arr_wdata` is the returned data.
- R4: On the first beat of a fill, `cpu_valid` is high in that same cycle and `cpu_data` equals `mem_rsp_data`.
- R5: `line_valid` is low after reset. It goes low in the cycle after a miss is accepted and goes high only in the cycle after the last of the WORDS beats has been written.
- R6: A second access (`cpu_rd_valid`, `cpu_rd_off`) during a fill, to a word that has already been written, gives `cpu_valid` in the same cycle with that word's data.
- R7: A second access to a word that has not yet arrived gives no `cpu_valid` in its own cycle. `cpu_stall` is high from the next cycle until the cycle in which that word arrives. In that cycle `cpu_valid` is high with the arriving data, and `cpu_stall` is low in the cycle after.
- R8: While `fill_busy` is low, `mem_rsp_valid` and `cpu_rd_valid` have no effect: `arr_we` and `cpu_valid` stay low.
- R9: Directly after reset, `fill_busy`, `line_valid`, `arr_we`, `cpu_valid`, `cpu_stall` and `mem_req_valid` (with no miss) are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | CPU miss request |
| miss_line | input | LINE_W | Line address of the miss |
| miss_off | input | OFF_W | Word offset the CPU needs |
| fill_busy | output | 1 | Fill in progress; misses not accepted |
| mem_req_valid | output | 1 | Memory request for a line, critical word first |
| mem_req_line | output | LINE_W | Requested line |
| mem_req_off | output | OFF_W | Word memory must return first |
| mem_rsp_valid | input | 1 | One returned word this cycle |
| mem_rsp_data | input | DATA_W | Returned word |
| arr_we | output | 1 | Data array word write enable |
| arr_line | output | LINE_W | Line being written |
| arr_off | output | OFF_W | Word position being written |
| arr_wdata | output | DATA_W | Word being written |
| line_valid | output | 1 | Line completely filled |
| cpu_rd_valid | input | 1 | Second access to the filling line |
| cpu_rd_off | input | OFF_W | Word offset of the second access |
| cpu_valid | output | 1 | Word delivered to the CPU |
| cpu_data | output | DATA_W | Delivered word |
| cpu_stall | output | 1 | Second access waiting for its word |

## Verification
The assertions assume that memory answers each request with exactly WORDS beats in wrap-around order, and only after the request. They also assume the CPU issues a second access only while a fill is in progress, only after the critical word has been delivered, and never while an earlier one is still stalled. The bench's memory model returns beats in wrap order with random gaps and stops after WORDS beats. Its CPU model raises a second access in the fill phase only when those conditions hold. Outside a fill, the bench deliberately drives stray returns and accesses to exercise R8.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  // position of the k-th returned beat when the fill starts at word base
  function automatic int unsigned beat_offset(input int unsigned base,
                                              input int unsigned k,
                                              input int unsigned words);
    return (base + k) % words;
  endfunction
endpackage

// File: rtl/cwf_fill_seq.sv
module cwf_fill_seq #(
  parameter int WORDS = 8,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [OFF_W-1:0] start_off_i,
  input  logic             beat_i,
  output logic             busy_o,
  output logic [OFF_W-1:0] off_o,
  output logic             first_o,
  output logic             last_o
);
  logic             busy_q;
  logic [OFF_W-1:0] base_q;
  logic [OFF_W-1:0] cnt_q;

  assign busy_o  = busy_q;
  assign first_o = busy_q && (cnt_q == '0);
  assign last_o  = busy_q && (cnt_q == OFF_W'(WORDS - 1));
  assign off_o   = OFF_W'(cwf_pkg::beat_offset(32'(base_q), 32'(cnt_q), 32'(WORDS)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      base_q <= start_off_i;
      cnt_q  <= '0;
    end else if (busy_q && beat_i) begin
      if (last_o) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cwf_line_buf.sv
module cwf_line_buf #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [OFF_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [WORDS-1:0]  have_o
);
  logic [DATA_W-1:0] word_q [WORDS];
  logic [WORDS-1:0]  have_q;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[g] <= '0;
        have_q[g] <= 1'b0;
      end else if (clear_i) begin
        have_q[g] <= 1'b0;
      end else if (we_i && (waddr_i == OFF_W'(g))) begin
        word_q[g] <= wdata_i;
        have_q[g] <= 1'b1;
      end
    end
  end

  assign rdata_o = word_q[raddr_i];
  assign have_o  = have_q;
endmodule

// File: rtl/cwf_restart.sv
module cwf_restart #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              first_i,
  input  logic              beat_i,
  input  logic [OFF_W-1:0]  beat_off_i,
  input  logic [DATA_W-1:0] beat_data_i,
  input  logic              rd_valid_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  input  logic              rd_have_i,
  input  logic [DATA_W-1:0] buf_data_i,
  output logic              cpu_valid_o,
  output logic [DATA_W-1:0] cpu_data_o,
  output logic              stall_o
);
  logic             pend_q;
  logic [OFF_W-1:0] pend_off_q;
  logic crit_fire, rd_now, rd_from_buf, new_match, pend_match;

  assign crit_fire   = busy_i && beat_i && first_i;
  assign rd_now      = busy_i && rd_valid_i && !pend_q;
  assign rd_from_buf = rd_now && rd_have_i;
  assign new_match   = rd_now && !rd_have_i && beat_i && (beat_off_i == rd_off_i);
  assign pend_match  = pend_q && beat_i && (beat_off_i == pend_off_q);

  assign cpu_valid_o = crit_fire || rd_from_buf || new_match || pend_match;
  assign cpu_data_o  = rd_from_buf ? buf_data_i : beat_data_i;
  assign stall_o     = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_off_q <= '0;
    end else if (rd_now && !rd_have_i && !new_match) begin
      pend_q     <= 1'b1;
      pend_off_q <= rd_off_i;
    end else if (pend_match) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int LINE_W = 10,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [LINE_W-1:0] miss_line,
  input  logic [OFF_W-1:0]  miss_off,
  output logic              fill_busy,
  output logic              mem_req_valid,
  output logic [LINE_W-1:0] mem_req_line,
  output logic [OFF_W-1:0]  mem_req_off,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              arr_we,
  output logic [LINE_W-1:0] arr_line,
  output logic [OFF_W-1:0]  arr_off,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              line_valid,
  input  logic              cpu_rd_valid,
  input  logic [OFF_W-1:0]  cpu_rd_off,
  output logic              cpu_valid,
  output logic [DATA_W-1:0] cpu_data,
  output logic              cpu_stall
);
  logic              accept_w, beat_w, first_beat, last_beat;
  logic [OFF_W-1:0]  beat_off;
  logic [LINE_W-1:0] line_q;
  logic              line_valid_q;
  logic [WORDS-1:0]  have_w;
  logic [DATA_W-1:0] buf_rdata;

  assign accept_w = miss_valid && !fill_busy;
  assign beat_w   = fill_busy && mem_rsp_valid;

  cwf_fill_seq #(.WORDS(WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(accept_w), .start_off_i(miss_off),
    .beat_i(mem_rsp_valid), .busy_o(fill_busy), .off_o(beat_off),
    .first_o(first_beat), .last_o(last_beat)
  );

  cwf_line_buf #(.WORDS(WORDS), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clear_i(accept_w), .we_i(beat_w),
    .waddr_i(beat_off), .wdata_i(mem_rsp_data), .raddr_i(cpu_rd_off),
    .rdata_o(buf_rdata), .have_o(have_w)
  );

  cwf_restart #(.WORDS(WORDS), .DATA_W(DATA_W)) u_rst (
    .clk(clk), .rst_n(rst_n), .busy_i(fill_busy), .first_i(first_beat),
    .beat_i(beat_w), .beat_off_i(beat_off), .beat_data_i(mem_rsp_data),
    .rd_valid_i(cpu_rd_valid), .rd_off_i(cpu_rd_off), .rd_have_i(have_w[cpu_rd_off]),
    .buf_data_i(buf_rdata), .cpu_valid_o(cpu_valid), .cpu_data_o(cpu_data),
    .stall_o(cpu_stall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q       <= '0;
      line_valid_q <= 1'b0;
    end else if (accept_w) begin
      line_q       <= miss_line;
      line_valid_q <= 1'b0;
    end else if (beat_w && last_beat) begin
      line_valid_q <= 1'b1;
    end
  end

  assign mem_req_valid = accept_w;
  assign mem_req_line  = miss_line;
  assign mem_req_off   = miss_off;
  assign arr_we        = beat_w;
  assign arr_line      = line_q;
  assign arr_off       = beat_off;
  assign arr_wdata     = mem_rsp_data;
  assign line_valid    = line_valid_q;
endmodule

// File: rtl/cwf_line_fill_chk.sv
module cwf_line_fill_chk #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(WORDS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fill_busy,
  input logic              mem_req_valid,
  input logic [OFF_W-1:0]  mem_req_off,
  input logic              arr_we,
  input logic [OFF_W-1:0]  arr_off,
  input logic [DATA_W-1:0] arr_wdata,
  input logic              line_valid,
  input logic              cpu_valid,
  input logic [DATA_W-1:0] cpu_data,
  input logic              cpu_stall,
  input logic              first_beat,
  input logic              last_beat
);
  logic [OFF_W-1:0] req_off_q, prev_off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_off_q  <= '0;
      prev_off_q <= '0;
    end else begin
      if (mem_req_valid) req_off_q <= mem_req_off;
      if (arr_we) prev_off_q <= arr_off;
    end
  end

  AST_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !fill_busy); // R1
  AST_BUSY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> fill_busy); // R2
  AST_FIRST_AT_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && first_beat) |-> (arr_off == req_off_q)); // R3
  AST_WRAP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && !first_beat) |-> (arr_off == OFF_W'(prev_off_q + 1'b1))); // R3
  AST_CRIT_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && first_beat) |-> (cpu_valid && cpu_data == arr_wdata)); // R4
  AST_LINE_VALID_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && last_beat) |=> (line_valid && !fill_busy)); // R5
  AST_NO_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> !line_valid); // R5
  AST_STALL_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> fill_busy); // R7
  AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stall && cpu_valid) |=> !cpu_stall); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_busy |-> (!arr_we && !cpu_valid)); // R8
endmodule

bind cwf_line_fill cwf_line_fill_chk #(.WORDS(WORDS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill_busy(fill_busy), .mem_req_valid(mem_req_valid),
  .mem_req_off(mem_req_off), .arr_we(arr_we), .arr_off(arr_off), .arr_wdata(arr_wdata),
  .line_valid(line_valid), .cpu_valid(cpu_valid), .cpu_data(cpu_data),
  .cpu_stall(cpu_stall), .first_beat(first_beat), .last_beat(last_beat)
);

// File: tb/cwf_line_fill_bench.sv
`timescale 1ns/1ps
module cwf_line_fill_bench;
  localparam int WORDS = 8, DATA_W = 32, LINE_W = 10, OFF_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic miss_valid = 1'b0, mem_rsp_valid = 1'b0, cpu_rd_valid = 1'b0;
  logic [LINE_W-1:0] miss_line = '0;
  logic [OFF_W-1:0]  miss_off = '0, cpu_rd_off = '0;
  logic [DATA_W-1:0] mem_rsp_data = '0;
  logic fill_busy, mem_req_valid, arr_we, line_valid, cpu_valid, cpu_stall;
  logic [LINE_W-1:0] mem_req_line, arr_line;
  logic [OFF_W-1:0]  mem_req_off, arr_off;
  logic [DATA_W-1:0] arr_wdata, cpu_data;

  always #4 clk = ~clk;

  cwf_line_fill #(.WORDS(WORDS), .DATA_W(DATA_W), .LINE_W(LINE_W)) u_cwf_line_fill (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_line(miss_line),
    .miss_off(miss_off), .fill_busy(fill_busy), .mem_req_valid(mem_req_valid),
    .mem_req_line(mem_req_line), .mem_req_off(mem_req_off),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .arr_we(arr_we),
    .arr_line(arr_line), .arr_off(arr_off), .arr_wdata(arr_wdata),
    .line_valid(line_valid), .cpu_rd_valid(cpu_rd_valid), .cpu_rd_off(cpu_rd_off),
    .cpu_valid(cpu_valid), .cpu_data(cpu_data), .cpu_stall(cpu_stall)
  );

  int checks = 0, bad = 0;
  bit done = 0;

  // reference state
  bit m_busy = 0, m_lvalid = 0, m_pend = 0;
  int m_base = 0, m_cnt = 0, m_line = 0, m_pend_off = 0;
  bit m_have[WORDS];
  logic [DATA_W-1:0] m_buf[WORDS];
  // memory model
  bit mem_on = 0;
  int mem_line = 0, mem_base = 0, mem_k = 0;

  function automatic logic [DATA_W-1:0] gen_data(int line, int off);
    return 32'(line * 256 + off * 17) ^ 32'hA53C_0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic one_cycle();
    bit e_acc, e_wr, crit, rd_now, rd_buf, new_m, pend_m, e_cv;
    int wr_off;
    logic [DATA_W-1:0] e_data;
    string tag;
    @(negedge clk);
    miss_valid = ($urandom_range(0, 9) == 0);
    miss_line  = LINE_W'($urandom_range(0, 1023));
    miss_off   = OFF_W'($urandom_range(0, WORDS - 1));
    mem_rsp_valid = 1'b0;
    if (mem_on && $urandom_range(0, 2) != 0) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = gen_data(mem_line, (mem_base + mem_k) % WORDS);
    end else if (!mem_on && $urandom_range(0, 7) == 0) begin
      mem_rsp_valid = 1'b1;                 // stray return while idle (R8)
      mem_rsp_data  = $urandom;
    end
    cpu_rd_valid = 1'b0;
    if (m_busy && m_cnt >= 1 && !m_pend) cpu_rd_valid = ($urandom_range(0, 3) == 0);
    else if (!m_busy) cpu_rd_valid = ($urandom_range(0, 7) == 0);
    cpu_rd_off = OFF_W'($urandom_range(0, WORDS - 1));
    #1;
    e_acc  = miss_valid && !m_busy;
    e_wr   = m_busy && mem_rsp_valid;
    wr_off = (m_base + m_cnt) % WORDS;
    crit   = e_wr && (m_cnt == 0);
    rd_now = m_busy && cpu_rd_valid && !m_pend;
    rd_buf = rd_now && m_have[cpu_rd_off];
    new_m  = rd_now && !m_have[cpu_rd_off] && e_wr && (wr_off == int'(cpu_rd_off));
    pend_m = m_pend && e_wr && (wr_off == m_pend_off);
    e_cv   = crit || rd_buf || new_m || pend_m;
    e_data = rd_buf ? m_buf[cpu_rd_off] : mem_rsp_data;

    tag = (miss_valid && m_busy) ? "R2 miss ignored while busy" : "R1 request";
    chk(mem_req_valid == e_acc, tag, 64'(mem_req_valid), 64'(e_acc));
    if (e_acc) begin
      chk(mem_req_line == miss_line, "R1 request line", 64'(mem_req_line), 64'(miss_line));
      chk(mem_req_off == miss_off, "R1 critical offset", 64'(mem_req_off), 64'(miss_off));
    end
    chk(fill_busy == m_busy, "R2 busy", 64'(fill_busy), 64'(m_busy));
    chk(arr_we == e_wr, m_busy ? "R3 write strobe" : "R8 idle return ignored",
        64'(arr_we), 64'(e_wr));
    if (e_wr) begin
      chk(int'(arr_off) == wr_off, "R3 wrap offset", 64'(arr_off), 64'(wr_off));
      chk(int'(arr_line) == m_line, "R3 line", 64'(arr_line), 64'(m_line));
      chk(arr_wdata == mem_rsp_data, "R3 data", 64'(arr_wdata), 64'(mem_rsp_data));
    end
    chk(line_valid == m_lvalid, "R5 line valid", 64'(line_valid), 64'(m_lvalid));
    if (crit) tag = "R4 critical forward";
    else if (rd_buf) tag = "R6 buffered read";
    else if (new_m || pend_m) tag = "R7 stalled read release";
    else if (!m_busy) tag = "R8 idle access ignored";
    else tag = "R7 no early delivery";
    chk(cpu_valid == e_cv, tag, 64'(cpu_valid), 64'(e_cv));
    if (e_cv) chk(cpu_data == e_data, tag, 64'(cpu_data), 64'(e_data));
    chk(cpu_stall == m_pend, "R7 stall", 64'(cpu_stall), 64'(m_pend));

    @(posedge clk);
    if (e_acc) begin
      m_busy = 1; m_base = int'(miss_off); m_cnt = 0; m_line = int'(miss_line); m_lvalid = 0;
      foreach (m_have[i]) m_have[i] = 0;
      mem_on = 1; mem_line = int'(miss_line); mem_base = int'(miss_off); mem_k = 0;
    end
    if (e_wr) begin
      m_have[wr_off] = 1;
      m_buf[wr_off]  = mem_rsp_data;
      if (m_cnt == WORDS - 1) begin m_busy = 0; m_lvalid = 1; end
      else m_cnt++;
    end
    if (rd_now && !m_have[cpu_rd_off] && !new_m && !(e_wr && wr_off == int'(cpu_rd_off))) begin
      m_pend = 1; m_pend_off = int'(cpu_rd_off);
    end else if (pend_m) m_pend = 0;
    if (mem_rsp_valid && mem_on) begin
      mem_k++;
      if (mem_k == WORDS) mem_on = 0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(fill_busy == 0, "R9 reset busy", 64'(fill_busy), 0);
    chk(line_valid == 0, "R9 reset line valid", 64'(line_valid), 0);
    chk(arr_we == 0 && cpu_valid == 0 && cpu_stall == 0 && mem_req_valid == 0,
        "R9 reset outputs", 64'({arr_we, cpu_valid, cpu_stall, mem_req_valid}), 0);
    rst_n = 1'b1;
    for (int c = 0; c < 6000; c++) one_cycle();
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule